// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The block gathers eight interrupt inputs and tells a processor which one to serve. Software talks to it over a byte-wide bus with one select bit, which picks either a command port or a data port. It keeps three eight-bit registers: requests that are waiting, levels now in service, and a mask. A rising edge on an input latches a request. The request stays latched only while the input stays high. The highest-priority unmasked request that beats everything already in service raises the interrupt output.

Before normal use, a command-port byte starts a short initialization sequence on the data port. That sequence sets the vector base and, depending on two flags in the opening byte, also takes a cascade byte and a mode byte. After that, data-port writes load the mask. Command-port bytes can end the current interrupt, choose which register a command-port read returns, or arm a one-shot polled acknowledge.

The processor acknowledges an interrupt either with a strobe on a dedicated input, which returns an eight-bit vector, or with a polled read of the command port. In both cases the chosen request moves into the in-service register. If nothing valid is waiting at acknowledge time, the controller reports level 7 and leaves the in-service register alone. Software detects this spurious case by reading in-service bit 7 and finding it clear.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, int_out is low and command-port reads return the request register.
- R2: A command-port write with bit 4 set starts initialization. It clears the request and in-service registers, sets the mask to 0xFF and disarms polling. The data-port writes that follow are taken in order as: vector base (bits 7:3 kept); a cascade byte, skipped if bit 1 of the start byte was 1; and a mode byte, taken only if bit 0 of the start byte was 1. None of these bytes changes the mask.
- R3: Once initialization is complete, a data-port write loads the mask, where a 1 bit disables that input, and a data-port read returns the mask. With the mask at 0xFF, int_out is low.
- R4: A request bit is set by a rising edge of its input and is cleared while that input is low. The request register can be read back on the command port.
- R5: Priority is fixed, with input 0 highest. int_out is high exactly when some unmasked request has a lower index than every bit set in the in-service register.
- R6: While ack is high, vec_out equals the vector base bits 7:3 joined with the 3-bit winning level. At that clock edge the winning bit moves from the request register to the in-service register.
- R7: If ack is given, or a poll read is made, with no valid request, the level reported is 7 and the in-service register is unchanged.
- R8: Command byte 0x20 clears the lowest-index set bit of the in-service register. Any other command byte whose bits 4:3 are 00 and whose bits 7:5 are not 001 has no effect.
- R9: A command byte with bits 4:3 = 01 and bit 1 = 1 selects what command-port reads return: bit 0 = 1 selects in-service (0x0B) and bit 0 = 0 selects request (0x0A). The choice persists until changed.
- R10: Command byte 0x0C arms polling. The next command-port read returns {valid, 4'b0000, level} and acts as an acknowledge. Reads after it return the selected register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt inputs, index 0 highest priority |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| ack | input | 1 | Vectored acknowledge strobe, one cycle |
| vec_out | output | 8 | Vector, valid while ack is high |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that irq_in is synchronous to clk and that wr_en and rd_en are never high in the same cycle. They also assume that ack is a single-cycle strobe that does not coincide with a polled read. The random stimulus chooses exactly one bus action or acknowledge per cycle, so these conditions always hold. Inputs change only on the falling edge, and input toggles are kept sparse so that requests live long enough to be acknowledged, masked or lost as spurious.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_IRQ = 8;
  localparam int LVL_W   = $clog2(NUM_IRQ);
  localparam int DATA_W  = 8;
  localparam int BASE_W  = DATA_W - LVL_W;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;

  // Index of the lowest set bit; NUM_IRQ when none is set.
  function automatic logic [LVL_W:0] first_set(input logic [NUM_IRQ-1:0] v);
    logic [LVL_W:0] r;
    r = NUM_IRQ[LVL_W:0];
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) r = i[LVL_W:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] clr,
  input  logic               flush,
  output logic [NUM_IRQ-1:0] irr_q
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] rise;
  logic [NUM_IRQ-1:0] irr_d;

  always_comb begin
    rise = irq_in & ~prev_q;
    if (flush) irr_d = '0;
    else       irr_d = ((irr_q & ~clr) | rise) & irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  // A latched request never survives a cycle in which its input was low.
  assert_req_needs_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q & ~$past(irq_in)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] imr,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               req_valid,
  output logic [LVL_W-1:0]   req_lvl,
  output logic               isr_any,
  output logic [LVL_W-1:0]   isr_lvl
);
  logic [LVL_W:0] p_idx;
  logic [LVL_W:0] s_idx;

  always_comb begin
    p_idx     = first_set(irr & ~imr);
    s_idx     = first_set(isr);
    req_valid = (p_idx < s_idx);
    req_lvl   = p_idx[LVL_W-1:0];
    isr_any   = ~s_idx[LVL_W];
    isr_lvl   = s_idx[LVL_W-1:0];
  end
endmodule

// File: rtl/irqc_cmd.sv
module irqc_cmd
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] imr_q,
  output logic [BASE_W-1:0] base_q,
  output logic              sel_isr_q,
  output logic              poll_q,
  output logic              init_start,
  output logic              eoi,
  output logic              poll_take
);
  init_st_t          st_q, st_d;
  logic              need_casc_q, need_casc_d;
  logic              need_mode_q, need_mode_d;
  logic [DATA_W-1:0] imr_d;
  logic [BASE_W-1:0] base_d;
  logic              sel_isr_d, poll_d;
  logic              cmd_wr, data_wr;

  always_comb begin
    cmd_wr      = wr_en & ~port_sel;
    data_wr     = wr_en & port_sel;
    init_start  = cmd_wr & wdata[4];
    eoi         = cmd_wr & ~wdata[4] & ~wdata[3] & (wdata[7:5] == 3'b001);
    poll_take   = rd_en & ~port_sel & poll_q;
    st_d        = st_q;
    need_casc_d = need_casc_q;
    need_mode_d = need_mode_q;
    imr_d       = imr_q;
    base_d      = base_q;
    sel_isr_d   = sel_isr_q;
    poll_d      = poll_q & ~poll_take;
    if (init_start) begin
      st_d        = ST_BASE;
      need_casc_d = ~wdata[1];
      need_mode_d = wdata[0];
      imr_d       = '1;
      sel_isr_d   = 1'b0;
      poll_d      = 1'b0;
    end else if (cmd_wr && wdata[4:3] == 2'b01) begin
      if (wdata[2]) poll_d = 1'b1;
      if (wdata[1]) sel_isr_d = wdata[0];
    end else if (data_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_d = wdata[DATA_W-1:LVL_W];
          if (need_casc_q)      st_d = ST_CASC;
          else if (need_mode_q) st_d = ST_MODE;
          else                  st_d = ST_RUN;
        end
        ST_CASC: st_d = need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: st_d = ST_RUN;
        default: imr_d = wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      imr_q       <= '1;
      base_q      <= '0;
      sel_isr_q   <= 1'b0;
      poll_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      need_casc_q <= need_casc_d;
      need_mode_q <= need_mode_d;
      imr_q       <= imr_d;
      base_q      <= base_d;
      sel_isr_q   <= sel_isr_d;
      poll_q      <= poll_d;
    end
  end

  assert_init_masks_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && wdata[4]) |=> (imr_q == '1 && st_q == ST_BASE));

  assert_poll_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !port_sel && poll_q && !wr_en) |=> !poll_q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               port_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               ack,
  output logic [DATA_W-1:0]  vec_out,
  output logic               int_out
);
  logic [NUM_IRQ-1:0] irr_q, isr_q, isr_d, imr_q;
  logic [NUM_IRQ-1:0] win_bit, eoi_bit;
  logic [BASE_W-1:0]  base_q;
  logic               sel_isr_q, poll_q, init_start, eoi, poll_take;
  logic               req_valid, isr_any, take;
  logic [LVL_W-1:0]   req_lvl, isr_lvl, take_lvl;

  irqc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wdata(wdata), .imr_q(imr_q), .base_q(base_q), .sel_isr_q(sel_isr_q),
    .poll_q(poll_q), .init_start(init_start), .eoi(eoi), .poll_take(poll_take)
  );

  irqc_prio u_prio (
    .irr(irr_q), .imr(imr_q), .isr(isr_q), .req_valid(req_valid),
    .req_lvl(req_lvl), .isr_any(isr_any), .isr_lvl(isr_lvl)
  );

  irqc_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(win_bit),
    .flush(init_start), .irr_q(irr_q)
  );

  always_comb begin
    take     = ack | poll_take;
    take_lvl = req_valid ? req_lvl : '1;
    win_bit  = (take && req_valid) ? (NUM_IRQ'(1) << req_lvl) : '0;
    eoi_bit  = (eoi && isr_any) ? (NUM_IRQ'(1) << isr_lvl) : '0;
    if (init_start) isr_d = '0;
    else            isr_d = (isr_q & ~eoi_bit) | win_bit;
    int_out  = req_valid;
    vec_out  = ack ? {base_q, take_lvl} : '0;
    if (port_sel)       rdata = imr_q;
    else if (poll_q)    rdata = {req_valid, {(DATA_W-LVL_W-1){1'b0}}, take_lvl};
    else if (sel_isr_q) rdata = isr_q;
    else                rdata = irr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assert_ack_moves_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid && !init_start) |=> (isr_q[$past(req_lvl)] && !irr_q[$past(req_lvl)]));

  assert_spurious_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_valid && !eoi && !init_start) |=> (isr_q == $past(isr_q)));

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_any && !take && !init_start) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

  assert_full_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '1) |-> !int_out);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec_out;
  logic       int_out;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 8'hFF, m_prev = 0;
  logic [4:0] m_base = 0;
  int         m_st = 0;            // 0 run, 1 base, 2 cascade, 3 mode
  logic       m_casc = 0, m_mode = 0, m_sel_isr = 0, m_poll = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .ack(ack),
    .vec_out(vec_out), .int_out(int_out)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_valid();
    return lowest(m_irr & ~m_imr) < lowest(m_isr);
  endfunction

  function automatic logic [2:0] m_lvl();
    return m_valid() ? 3'(lowest(m_irr & ~m_imr)) : 3'd7;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_clock(input logic [7:0] irq, input bit wr, input bit rd,
                             input bit sel, input logic [7:0] wd, input bit ak);
    bit cmd_wr, data_wr, take, init, eoi, v;
    logic [7:0] rise, set, eclr;
    int p, s;
    cmd_wr  = wr && !sel;
    data_wr = wr && sel;
    take    = ak || (rd && !sel && m_poll);
    init    = cmd_wr && wd[4];
    eoi     = cmd_wr && wd[4:3] == 2'b00 && wd[7:5] == 3'b001;
    v       = m_valid();
    p       = lowest(m_irr & ~m_imr);
    s       = lowest(m_isr);
    rise    = irq & ~m_prev;
    set     = (take && v) ? 8'(1 << p) : 8'h00;
    eclr    = (eoi && s < 8) ? 8'(1 << s) : 8'h00;
    if (rd && !sel && m_poll) m_poll = 0;
    if (init) begin
      m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_sel_isr = 0; m_poll = 0;
      m_st = 1; m_casc = !wd[1]; m_mode = wd[0];
    end else begin
      m_irr = ((m_irr & ~set) | rise) & irq;
      m_isr = (m_isr & ~eclr) | set;
      if (cmd_wr && wd[4:3] == 2'b01) begin
        if (wd[2]) m_poll = 1;
        if (wd[1]) m_sel_isr = wd[0];
      end else if (data_wr) begin
        case (m_st)
          1: begin m_base = wd[7:3]; m_st = m_casc ? 2 : (m_mode ? 3 : 0); end
          2: m_st = m_mode ? 3 : 0;
          3: m_st = 0;
          default: m_imr = wd;
        endcase
      end
    end
    m_prev = irq;
  endtask

  // One bus cycle: drive after falling edge, check before rising edge.
  task automatic cyc(input logic [7:0] irq, input bit wr, input bit rd, input bit sel,
                     input logic [7:0] wd, input bit ak, input string tag);
    irq_in = irq; wr_en = wr; rd_en = rd; port_sel = sel; wdata = wd; ack = ak;
    #3;
    check("R5 int_out", {7'd0, int_out}, {7'd0, m_valid()});
    if (ak) check(m_valid() ? "R6 vector" : "R7 spurious vector", vec_out, {m_base, m_lvl()});
    if (rd) begin
      if (sel)         check({tag, " R3 mask read"}, rdata, m_imr);
      else if (m_poll) check({tag, " R10 poll byte"}, rdata, {m_valid(), 4'b0000, m_lvl()});
      else if (m_sel_isr) check({tag, " R9 in-service read"}, rdata, m_isr);
      else             check({tag, " R4 request read"}, rdata, m_irr);
    end
    @(posedge clk);
    model_clock(irq, wr, rd, sel, wd, ak);
    @(negedge clk);
    wr_en = 0; rd_en = 0; ack = 0;
  endtask

  task automatic cmd_w(input logic [7:0] b);  cyc(irq_in, 1, 0, 0, b, 0, "cmd"); endtask
  task automatic data_w(input logic [7:0] b); cyc(irq_in, 1, 0, 1, b, 0, "data"); endtask
  task automatic cmd_r(input string t);       cyc(irq_in, 0, 1, 0, 0, 0, t); endtask
  task automatic data_r(input string t);      cyc(irq_in, 0, 1, 1, 0, 0, t); endtask
  task automatic set_irq(input logic [7:0] v); cyc(v, 0, 0, 0, 0, 0, "irq"); endtask
  task automatic do_ack();                    cyc(irq_in, 0, 0, 0, 0, 1, "ack"); endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1D5C);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    data_r("R1");
    cmd_r("R1");
    check("R1 int_out", {7'd0, int_out}, 8'd0);
    // R2: full four-byte init, base 0x08
    cmd_w(8'h11); data_w(8'h08); data_w(8'h04); data_w(8'h11);
    data_r("R2 mask untouched by init bytes");
    // R3: unmask, raise inputs 3 and 5
    data_w(8'h00);
    set_irq(8'h28);
    cmd_r("R4 latched edges");
    do_ack();                           // R6: level 3 served
    cmd_w(8'h0B); cmd_r("R9 isr after ack");
    do_ack();                           // level 5 lower priority than 3: spurious R7
    cmd_w(8'h20);                       // R8: clear level 3
    cmd_r("R8 after eoi");
    cmd_w(8'h40);                       // R8: ignored command
    cmd_r("R8 ignored command");
    do_ack();                           // level 5 now served
    cmd_w(8'h20); cmd_r("R8 second eoi");
    // R7: request vanishes before acknowledge
    set_irq(8'h00); set_irq(8'h20); set_irq(8'h00);
    do_ack(); cmd_r("R7 isr stays clear");
    // R10: polled acknowledge
    set_irq(8'h04);
    cmd_w(8'h0C); cmd_r("R10 poll"); cmd_r("R10 after poll");
    cmd_w(8'h0A); cmd_r("R9 back to request");
    cmd_w(8'h20);
    // R3: mask blocks input 2
    data_w(8'h04); set_irq(8'h00); set_irq(8'h04);
    check("R3 masked int_out", {7'd0, int_out}, 8'd0);
    cmd_r("R4 masked request still latched");
    // R2: short init (single, with mode byte), base 0x20
    cmd_w(8'h13); data_w(8'h20); data_w(8'h01);
    data_r("R2 short init");
    data_w(8'h00); data_r("R3 mask after short init");
    set_irq(8'h00); set_irq(8'h80); do_ack();
    cmd_w(8'h20);
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] nirq;
      int op;
      nirq = irq_in ^ 8'($urandom & $urandom & $urandom);
      op = $urandom % 16;
      case (op)
        0, 1:    cyc(nirq, 0, 0, 0, 0, 1, "rand");
        2:       cyc(nirq, 1, 0, 0, 8'h20, 0, "rand");
        3:       cyc(nirq, 1, 0, 1, 8'($urandom & $urandom), 0, "rand");
        4:       cyc(nirq, 1, 0, 0, 8'h0B, 0, "rand");
        5:       cyc(nirq, 1, 0, 0, 8'h0A, 0, "rand");
        6:       cyc(nirq, 1, 0, 0, 8'h0C, 0, "rand");
        7, 8, 9: cyc(nirq, 0, 1, 0, 0, 0, "rand");
        10:      cyc(nirq, 0, 1, 1, 0, 0, "rand");
        default: cyc(nirq, 0, 0, 0, 0, 0, "rand");
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule